// File: doc/BRIEF.md
# Trapezoidal Duty-Profile PWM Generator

This block drives one pulse-width modulated output from a free-running up-counter that wraps every 2^CNT_W clock cycles. Each period the output goes high as the counter passes through zero and goes low when the counter equals the active compare value. The high time in clock cycles is therefore equal to that value. A compare value of half the counter range gives 50% duty, and zero gives 0% duty.

The compare value does not come from software. After a single start pulse, an internal sequencer walks it through a speed profile with three stages. First it climbs by a fixed step once per pulse until it reaches half range. It stays there for a fixed number of pulses. It then falls by the same step until it reaches zero. The sequencer counts pulses by watching rising edges of its own output. Each new value goes to a shadow register and takes effect only when the counter wraps. When the profile ends, the block raises a done flag and stays quiet until it is started again. The active compare value is brought out for observation.

Top module: `trap_pwm_seq`

## Requirements
- R1: Reset is synchronous. While reset is held and in the cycle after it, the output is low, the done flag is low and the observed compare value is 0. After reset the block stays idle and makes no pulse until a start pulse arrives.
- R2: A period lasts exactly 2^CNT_W clock cycles. The output rises only in the cycle after the counter reads 0. Consecutive pulses within one profile rise exactly 2^CNT_W cycles apart.
- R3: The output stays high for exactly as many clock cycles as the active compare value. It falls in the cycle after the counter equals that value.
- R4: An active compare value of 0 keeps the output low for the whole period, with no one-cycle spike. While idle, the block makes no pulses.
- R5: The observed compare value changes only in the cycle after the counter reads its all-ones value. A period's width therefore equals the compare value seen at its rising edge.
- R6: After a start pulse, pulse k of the climb (k = 1..RAMP_N) has width min(k·STEP, 2^(CNT_W-1)). The climb lasts exactly RAMP_N pulses.
- R7: The next HOLD_N pulses each have width 2^(CNT_W-1), which is 50% duty.
- R8: After the hold, each pulse is STEP narrower than the one before it, floored at 0. The profile ends once the value would reach 0. No pulse of width 0 is counted as a pulse.
- R9: The done flag is low throughout a profile. It rises during the last nonzero pulse and then stays high, with the output low and the compare value at 0, until the next start pulse. A start pulse while done is high begins a fresh profile.
- R10: A start pulse that arrives while a profile is running is ignored, and the pulse sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin a profile |
| pwm_o | output | 1 | PWM output |
| done_o | output | 1 | High once the profile has finished |
| cmp_o | output | CNT_W | Active (shadowed) compare value |

## Verification
The bench targets the edges of the profile. It checks the climb step that would overshoot half range, and a design without the clamp would show a width above 50%. It checks the last descending step, where the value would go below zero; without a floor the value would wrap to a huge width, and a design that ended one step early or late would show the wrong pulse count. It also checks that zero duty produces no spike, which would otherwise appear as an unexpected one-cycle pulse in idle or after done. Start pulses are injected during the climb and the hold; a design that restarted on them would shift the expected width sequence. A reset is also applied mid-profile, and a design that kept running afterwards would produce pulses that nobody expects.

// File: rtl/trap_pwm_pkg.sv
package trap_pwm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RISE = 3'd1,
    PH_HOLD = 3'd2,
    PH_FALL = 3'd3,
    PH_DONE = 3'd4
  } phase_e;

endpackage

// File: rtl/tpw_timebase.sv
module tpw_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  // last count of the period: the next edge starts a new one
  assign wrap_o = &cnt_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/tpw_compare_out.sv
module tpw_compare_out #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cmp_next_i,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             pwm_o
);

  logic [CNT_W-1:0] cmp_act_q;
  logic             pwm_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmp_act_q <= '0;
      pwm_q     <= 1'b0;
    end else begin
      // shadow load only on the period boundary
      if (wrap_i) cmp_act_q <= cmp_next_i;
      // match wins over period start: zero duty gives no spike
      if (cnt_i == cmp_act_q)  pwm_q <= 1'b0;
      else if (cnt_i == '0)    pwm_q <= 1'b1;
    end
  end

  assign cmp_act_o = cmp_act_q;
  assign pwm_o     = pwm_q;

endmodule

// File: rtl/tpw_sequencer.sv
module tpw_sequencer
  import trap_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STEP   = 216,
  parameter int RAMP_N = 152,
  parameter int HOLD_N = 152
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             pwm_i,
  output logic [CNT_W-1:0] cmp_next_o,
  output logic             done_o
);

  localparam int               MAX_N   = (RAMP_N > HOLD_N) ? RAMP_N : HOLD_N;
  localparam int               PC_W    = $clog2(MAX_N + 1);
  localparam logic [CNT_W:0]   STEP_X  = (CNT_W + 1)'(STEP);
  localparam logic [CNT_W-1:0] HALF_V  = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] FIRST_V = (STEP_X >= {1'b0, HALF_V}) ? HALF_V : STEP_X[CNT_W-1:0];
  localparam logic [PC_W-1:0]  RAMP_L  = PC_W'(RAMP_N - 1);
  localparam logic [PC_W-1:0]  HOLD_L  = PC_W'(HOLD_N - 1);

  phase_e           ph_q;
  logic [PC_W-1:0]  pc_q;
  logic [CNT_W-1:0] work_q;
  logic             pwm_d;
  logic             rise;
  logic             can_start;
  logic [CNT_W:0]   up_sum;
  logic [CNT_W-1:0] up_val;
  logic [CNT_W-1:0] dn_val;

  // pulses are counted from the block's own output edges
  assign rise      = pwm_i & ~pwm_d;
  assign can_start = start_i & ((ph_q == PH_IDLE) | (ph_q == PH_DONE));

  always_comb begin
    up_sum = {1'b0, work_q} + STEP_X;
    up_val = (up_sum >= {1'b0, HALF_V}) ? HALF_V : up_sum[CNT_W-1:0];
    dn_val = ({1'b0, work_q} > STEP_X) ? (work_q - STEP_X[CNT_W-1:0]) : '0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q   <= PH_IDLE;
      pc_q   <= '0;
      work_q <= '0;
      pwm_d  <= 1'b0;
    end else begin
      pwm_d <= pwm_i;
      if (can_start) begin
        ph_q   <= PH_RISE;
        pc_q   <= '0;
        work_q <= FIRST_V;
      end else if (rise) begin
        case (ph_q)
          PH_RISE: begin
            if (pc_q == RAMP_L) begin
              ph_q   <= PH_HOLD;
              pc_q   <= '0;
              work_q <= HALF_V;
            end else begin
              pc_q   <= pc_q + 1'b1;
              work_q <= up_val;
            end
          end
          PH_HOLD: begin
            if (pc_q == HOLD_L) begin
              ph_q   <= (dn_val == '0) ? PH_DONE : PH_FALL;
              pc_q   <= '0;
              work_q <= dn_val;
            end else begin
              pc_q <= pc_q + 1'b1;
            end
          end
          PH_FALL: begin
            work_q <= dn_val;
            if (dn_val == '0) ph_q <= PH_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign cmp_next_o = work_q;
  assign done_o     = (ph_q == PH_DONE);

endmodule

// File: rtl/trap_pwm_seq.sv
module trap_pwm_seq #(
  parameter int CNT_W  = 16,
  parameter int STEP   = 216,
  parameter int RAMP_N = 152,
  parameter int HOLD_N = 152
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  output logic             pwm_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cmp_o
);

  logic [CNT_W-1:0] tick_cnt;
  logic             tick_wrap;
  logic [CNT_W-1:0] cmp_next;
  logic             pwm_w;

  tpw_timebase #(.CNT_W(CNT_W)) tb_u (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cnt_o  (tick_cnt),
    .wrap_o (tick_wrap)
  );

  tpw_compare_out #(.CNT_W(CNT_W)) out_u (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cnt_i      (tick_cnt),
    .wrap_i     (tick_wrap),
    .cmp_next_i (cmp_next),
    .cmp_act_o  (cmp_o),
    .pwm_o      (pwm_w)
  );

  tpw_sequencer #(
    .CNT_W  (CNT_W),
    .STEP   (STEP),
    .RAMP_N (RAMP_N),
    .HOLD_N (HOLD_N)
  ) seq_u (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (start_i),
    .pwm_i      (pwm_w),
    .cmp_next_o (cmp_next),
    .done_o     (done_o)
  );

  assign pwm_o = pwm_w;

endmodule

// File: rtl/trap_pwm_seq_chk.sv
module trap_pwm_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             pwm_i,
  input logic             done_i,
  input logic [CNT_W-1:0] cmp_i,
  input logic [CNT_W-1:0] cnt_i
);

  localparam logic [CNT_W-1:0] TOP = '1;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (!pwm_i && !done_i && cmp_i == '0));

  // R2
  rise_at_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pwm_i) |-> $past(cnt_i) == '0);

  // R3
  fall_at_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $fell(pwm_i)) |-> $past(cnt_i) == $past(cmp_i));

  // R4
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmp_i == '0 && $past(cmp_i) == '0) |-> !pwm_i);

  // R5
  cmp_boundary_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(cmp_i)) |-> $past(cnt_i) == TOP);

  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_i |=> !$rose(pwm_i));

endmodule

bind trap_pwm_seq trap_pwm_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .pwm_i  (pwm_o),
  .done_i (done_o),
  .cmp_i  (cmp_o),
  .cnt_i  (tick_cnt)
);

// File: tb/trap_pwm_seq_tb_top.sv
module trap_pwm_seq_tb_top;

  localparam int CW   = 8;
  localparam int ST   = 24;
  localparam int RN   = 6;
  localparam int HN   = 4;
  localparam int PER  = 1 << CW;
  localparam int HALF = 1 << (CW - 1);

  logic          clk_i = 1'b0;
  logic          rst_i = 1'b1;
  logic          start_i = 1'b0;
  logic          pwm_o;
  logic          done_o;
  logic [CW-1:0] cmp_o;

  int checks = 0;
  int errors = 0;
  int rises  = 0;
  int exp_w[$];
  bit exp_last[$];

  always #5 clk_i = ~clk_i;

  trap_pwm_seq #(.CNT_W(CW), .STEP(ST), .RAMP_N(RN), .HOLD_N(HN)) dut_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .pwm_o   (pwm_o),
    .done_o  (done_o),
    .cmp_o   (cmp_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: expected widths of one full profile (R6 climb, R7 hold, R8 descent)
  task automatic push_profile();
    int w;
    for (int k = 1; k <= RN; k++) begin
      w = (k * ST > HALF) ? HALF : k * ST;
      exp_w.push_back(w); exp_last.push_back(1'b0);
    end
    for (int k = 0; k < HN; k++) begin
      exp_w.push_back(HALF); exp_last.push_back(1'b0);
    end
    w = HALF;
    for (int k = 0; k < 64; k++) begin
      w = w - ST;
      if (w <= 0) break;
      exp_w.push_back(w); exp_last.push_back(1'b0);
    end
    exp_last[exp_last.size() - 1] = 1'b1;
  endtask

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  // monitor: measures each pulse and pops the scoreboard
  bit prev_pwm, have_rise, last_end;
  int width, since, cmp_at;
  always @(negedge clk_i) begin
    if (rst_i) begin
      prev_pwm = 1'b0; have_rise = 1'b0; last_end = 1'b1;
      width = 0; since = 0;
    end else begin
      since++;
      if (pwm_o && !prev_pwm) begin
        rises++;
        if (have_rise && !last_end) chk(since == PER, "R2 period", since, PER);
        since = 0; have_rise = 1'b1; cmp_at = int'(cmp_o); width = 0;
        if (exp_w.size() == 0) chk(1'b0, "R4 unexpected pulse", 1, 0);
      end
      if (pwm_o) width++;
      if (!pwm_o && prev_pwm && exp_w.size() != 0) begin
        int e; bit l;
        e = exp_w.pop_front(); l = exp_last.pop_front();
        chk(width == e, "R3/R6/R7/R8 width", width, e);
        chk(cmp_at == e, "R5 compare at rise", cmp_at, e);
        chk(done_o == l, "R9 done flag", int'(done_o), int'(l));
        last_end = l;
      end
      prev_pwm = pwm_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int snap;
    repeat (4) @(negedge clk_i);
    // R1 reset state
    chk(pwm_o == 1'b0, "R1 pwm in reset", int'(pwm_o), 0);
    chk(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    chk(cmp_o == '0, "R1 cmp in reset", int'(cmp_o), 0);
    rst_i = 1'b0;

    // R4 idle, zero duty: no pulse
    repeat (3 * PER) @(negedge clk_i);
    chk(rises == 0, "R4 idle pulses", rises, 0);

    // profile one, with ignored starts (R10)
    push_profile();
    pulse_start();
    repeat (3 * PER + 40) @(negedge clk_i);
    pulse_start();
    repeat (4 * PER) @(negedge clk_i);
    pulse_start();
    for (int i = 0; i < 40 * PER && !done_o; i++) @(negedge clk_i);
    chk(done_o == 1'b1, "R9 done reached", int'(done_o), 1);
    repeat (3 * PER) @(negedge clk_i);
    chk(exp_w.size() == 0, "R10 sequence length", exp_w.size(), 0);
    chk(done_o == 1'b1, "R9 done held", int'(done_o), 1);
    chk(pwm_o == 1'b0, "R9 pwm quiet", int'(pwm_o), 0);
    chk(cmp_o == '0, "R9 cmp zero", int'(cmp_o), 0);

    // profile two: restart from done
    push_profile();
    pulse_start();
    repeat (PER) @(negedge clk_i);
    chk(done_o == 1'b0, "R9 done cleared on restart", int'(done_o), 0);
    for (int i = 0; i < 40 * PER && !done_o; i++) @(negedge clk_i);
    repeat (2 * PER) @(negedge clk_i);
    chk(exp_w.size() == 0, "R6 restart profile", exp_w.size(), 0);

    // profile three: reset mid-run
    push_profile();
    pulse_start();
    repeat (2 * PER + 20) @(negedge clk_i);
    while (pwm_o) @(negedge clk_i);
    rst_i = 1'b1;
    @(negedge clk_i);
    exp_w.delete(); exp_last.delete();
    chk(pwm_o == 1'b0, "R1 pwm after mid reset", int'(pwm_o), 0);
    chk(cmp_o == '0, "R1 cmp after mid reset", int'(cmp_o), 0);
    chk(done_o == 1'b0, "R1 done after mid reset", int'(done_o), 0);
    rst_i = 1'b0;
    snap = rises;
    repeat (3 * PER) @(negedge clk_i);
    chk(rises == snap, "R1 idle after reset", rises - snap, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule